// File: doc/BRIEF.md
# Trap Capture and Vector Unit

This block records the processor state when the normal instruction flow must be abandoned. A trap is taken when the core raises a synchronous fault line, or when an external interrupt is pending, enabled and unmasked. On that clock edge the unit does four things. It saves the address of the instruction that caused the trap into the exception PC. It writes a four-bit reason code into the cause register. It latches the faulting memory address when the trap came from a memory access. It clears the global interrupt enable. On the following cycle it issues a single redirect pulse that points the fetch stage at the fixed handler entry.

The core presents the PC value after it has already been incremented. The unit steps that value back by one instruction width, so the saved address names the instruction itself and not the one after it. External interrupt levels are latched as pending on every edge, whatever the status register holds. They stay latched until the handler acknowledges them. An interrupt that arrives while it is masked is therefore not lost.

The redirect output is a plain valid strobe with no ready. The fetch stage must act on it in the cycle it is high, and nothing is held back. All other pins are plain control or status signals.

Top module: `trap_capture_unit`

## Requirements
- R1: A trap decided at a clock edge makes `redirect_valid` high for exactly the next cycle, with `redirect_pc` = 0x8000_0080. In every other cycle `redirect_valid` is low.
- R2: When a trap is taken, `epc` is loaded with `pc_next` minus 4 as sampled at that edge. At all other times it holds its value.
- R3: A taken trap writes its code into `cause[5:2]`. The codes are: interrupt 0, load or fetch address error 4, store address error 5, fetch bus error 6, data bus error 7, syscall 8, breakpoint 9, reserved instruction 10, overflow 12.
- R4: When several sources are active in one cycle, the winner is decided in this order, highest first: fetch bus error, load/fetch address error, store address error, data bus error, reserved instruction, overflow, syscall, breakpoint, external interrupt.
- R5: `badaddr` captures `fault_addr` when the winning code is 4, 5, 6 or 7. For any other taken trap it keeps its value.
- R6: `cause[12:8]` shows five pending bits, with bit 8+i set at any edge where `irq[i]` is high, regardless of status. A pending bit clears only at an edge where `pend_clr[i]` is high and `irq[i]` is low; if both are high, set wins.
- R7: An interrupt trap (code 0) is taken only when `status[0]` (global enable) is 1 and some pending bit i has `status[8+i]` (unmask) = 1.
- R8: `stat_we` loads `status[0]` and `status[12:8]` from the same bits of `stat_wdata`. A taken trap forces `status[0]` to 0, and this wins over a write in the same cycle, while the mask bits still take the written value.
- R9: After reset all outputs are zero. Bits of `cause` other than 12:8 and 5:2, and bits of `status` other than 12:8 and 0, always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_next | input | 32 | Already-incremented PC of the instruction in question |
| req_ibus | input | 1 | Bus error on instruction fetch |
| req_adrl | input | 1 | Address error on load or fetch |
| req_adrs | input | 1 | Address error on store |
| req_dbus | input | 1 | Bus error on data access |
| req_rsvd | input | 1 | Reserved instruction |
| req_ovf | input | 1 | Arithmetic overflow |
| req_sys | input | 1 | System call |
| req_brk | input | 1 | Breakpoint |
| fault_addr | input | 32 | Memory address of the faulting access |
| irq | input | 5 | External interrupt levels |
| pend_clr | input | 5 | Per-level pending acknowledge |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Status write data |
| epc | output | 32 | Exception PC |
| cause | output | 32 | Cause: pending bits 12:8, code 5:2 |
| badaddr | output | 32 | Faulting data address |
| status | output | 32 | Status: unmask bits 12:8, global enable bit 0 |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Handler entry address |

## Verification
The hardest state to reach from the ports is an interrupt that arrived while masked and is taken much later, when software unmasks it. The bench pulses two interrupt lines for one cycle each while their mask bits are clear, and confirms that both show as pending together. It then writes the status register to unmask one of them and checks that the trap occurs exactly two edges later. It also checks that an acknowledge of that level leaves the other level pending. Sweeping all 256 combinations of the synchronous fault lines covers every priority pairing and the bad-address capture rule.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int unsigned NSRC     = 9;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned PEND_LSB = 8;
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned IE_BIT   = 0;

  typedef enum logic [3:0] {
    EC_INT  = 4'd0,
    EC_ADRL = 4'd4,
    EC_ADRS = 4'd5,
    EC_IBUS = 4'd6,
    EC_DBUS = 4'd7,
    EC_SYS  = 4'd8,
    EC_BRK  = 4'd9,
    EC_RSVD = 4'd10,
    EC_OVF  = 4'd12
  } exc_code_e;

  typedef struct packed {
    logic      take;
    exc_code_e code;
    logic      mem_fault;
  } trap_dec_t;

  // source index 0 is the most urgent
  function automatic exc_code_e code_of(input int idx);
    case (idx)
      0:       return EC_IBUS;
      1:       return EC_ADRL;
      2:       return EC_ADRS;
      3:       return EC_DBUS;
      4:       return EC_RSVD;
      5:       return EC_OVF;
      6:       return EC_SYS;
      7:       return EC_BRK;
      default: return EC_INT;
    endcase
  endfunction

  function automatic logic is_mem_code(input exc_code_e c);
    return (c == EC_ADRL) || (c == EC_ADRS) || (c == EC_IBUS) || (c == EC_DBUS);
  endfunction

endpackage

// File: rtl/trap_prio.sv
module trap_prio
  import trap_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] src,
  output trap_dec_t    dec
);
  always_comb begin
    dec = '{take: 1'b0, code: EC_INT, mem_fault: 1'b0};
    for (int i = N - 1; i >= 0; i--) begin
      if (src[i]) begin
        dec.take      = 1'b1;
        dec.code      = code_of(i);
        dec.mem_fault = is_mem_code(code_of(i));
      end
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] clr,
  input  logic            glob_en,
  input  logic [NIRQ-1:0] unmask,
  output logic [NIRQ-1:0] pend,
  output logic            want
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[g] <= 1'b0;
      else if (irq[g]) pend[g] <= 1'b1;
      else if (clr[g]) pend[g] <= 1'b0;
    end
  end

  assign want = glob_en && |(pend & unmask);
endmodule

// File: rtl/trap_regs.sv
module trap_regs
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NIRQ   = 5,
  parameter logic [31:0] VECTOR = 32'h8000_0080,
  parameter int unsigned STEP   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  trap_dec_t       dec,
  input  logic [XLEN-1:0] pc_next,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            stat_we,
  input  logic            wr_ie,
  input  logic [NIRQ-1:0] wr_mask,
  output logic [XLEN-1:0] epc,
  output exc_code_e       code_q,
  output logic [XLEN-1:0] badaddr,
  output logic            glob_en,
  output logic [NIRQ-1:0] unmask,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc            <= '0;
      code_q         <= EC_INT;
      badaddr        <= '0;
      redirect_valid <= 1'b0;
    end else begin
      redirect_valid <= dec.take;
      if (dec.take) begin
        epc    <= pc_next - STEP_W;
        code_q <= dec.code;
        if (dec.mem_fault) badaddr <= fault_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      unmask  <= '0;
    end else begin
      if (stat_we) unmask <= wr_mask;
      if (dec.take)     glob_en <= 1'b0;
      else if (stat_we) glob_en <= wr_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) redirect_pc <= '0;
    else if (dec.take) redirect_pc <= VECTOR[XLEN-1:0];
  end
endmodule

// File: rtl/trap_capture_unit.sv
module trap_capture_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NIRQ   = 5,
  parameter logic [31:0] VECTOR = 32'h8000_0080,
  parameter int unsigned STEP   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] pc_next,
  input  logic            req_ibus,
  input  logic            req_adrl,
  input  logic            req_adrs,
  input  logic            req_dbus,
  input  logic            req_rsvd,
  input  logic            req_ovf,
  input  logic            req_sys,
  input  logic            req_brk,
  input  logic [XLEN-1:0] fault_addr,
  input  logic [NIRQ-1:0] irq,
  input  logic [NIRQ-1:0] pend_clr,
  input  logic            stat_we,
  input  logic [XLEN-1:0] stat_wdata,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] badaddr,
  output logic [XLEN-1:0] status,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  logic [NIRQ-1:0] pend, unmask;
  logic            want_irq, glob_en;
  logic [NSRC-1:0] src;
  trap_dec_t       dec;
  exc_code_e       code_q;
  logic            unused_wbits;

  assign unused_wbits = ^{stat_wdata};

  assign src = {want_irq, req_brk, req_sys, req_ovf, req_rsvd,
                req_dbus, req_adrs, req_adrl, req_ibus};

  irq_pending #(.NIRQ(NIRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq(irq), .clr(pend_clr),
    .glob_en(glob_en), .unmask(unmask), .pend(pend), .want(want_irq)
  );

  trap_prio #(.N(NSRC)) u_prio (.src(src), .dec(dec));

  trap_regs #(.XLEN(XLEN), .NIRQ(NIRQ), .VECTOR(VECTOR), .STEP(STEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .dec(dec), .pc_next(pc_next),
    .fault_addr(fault_addr), .stat_we(stat_we),
    .wr_ie(stat_wdata[IE_BIT]), .wr_mask(stat_wdata[MASK_LSB +: NIRQ]),
    .epc(epc), .code_q(code_q), .badaddr(badaddr),
    .glob_en(glob_en), .unmask(unmask),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  always_comb begin
    cause = '0;
    cause[CODE_LSB +: 4]    = code_q;
    cause[PEND_LSB +: NIRQ] = pend;
    status = '0;
    status[IE_BIT]          = glob_en;
    status[MASK_LSB +: NIRQ] = unmask;
  end
endmodule

// File: rtl/trap_capture_chk.sv
module trap_capture_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NIRQ   = 5,
  parameter logic [31:0] VECTOR = 32'h8000_0080,
  parameter int unsigned STEP   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] pc_next,
  input logic            req_ibus,
  input logic            req_adrl,
  input logic            req_adrs,
  input logic            req_dbus,
  input logic            req_rsvd,
  input logic            req_ovf,
  input logic            req_sys,
  input logic            req_brk,
  input logic [XLEN-1:0] fault_addr,
  input logic [NIRQ-1:0] irq,
  input logic [NIRQ-1:0] pend_clr,
  input logic            stat_we,
  input logic [XLEN-1:0] stat_wdata,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] cause,
  input logic [XLEN-1:0] badaddr,
  input logic [XLEN-1:0] status,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc
);
  logic sync_any;
  logic [3:0] code_now;
  logic [XLEN-1:0] cause_spare, status_spare;
  assign sync_any = req_ibus | req_adrl | req_adrs | req_dbus |
                    req_rsvd | req_ovf | req_sys | req_brk;
  assign code_now = cause[5:2];
  assign cause_spare  = cause  & ~(XLEN'({NIRQ{1'b1}}) << 8) & ~XLEN'(32'h3C);
  assign status_spare = status & ~(XLEN'({NIRQ{1'b1}}) << 8) & ~XLEN'(1);

  // R1
  sync_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_any |=> redirect_valid && redirect_pc == VECTOR[XLEN-1:0]);
  // R2
  epc_step_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> epc == $past(pc_next) - XLEN'(STEP));
  // R8
  ie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !status[0]);
  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> status[12:8] == $past(stat_wdata[12:8]));
  // R7
  no_spurious_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_any && !status[0]) |=> !redirect_valid);
  // R6
  pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause[12:8] & $past(irq)) == $past(irq));
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause[12:8] & $past(pend_clr & ~irq)) == '0);
  // R5
  badaddr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && code_now >= 4'd4 && code_now <= 4'd7)
      |-> badaddr == $past(fault_addr));
  // R5
  badaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && (code_now < 4'd4 || code_now > 4'd7))
      |-> badaddr == $past(badaddr));
  // R9
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_spare == '0 && status_spare == '0);
endmodule

bind trap_capture_unit trap_capture_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .VECTOR(VECTOR), .STEP(STEP)
) u_chk (.*);

// File: tb/trap_capture_unit_tb.sv
`timescale 1ns/1ps
module trap_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_next = '0, fault_addr = '0, stat_wdata = '0;
  logic [7:0]  reqs = '0;
  logic [4:0]  irq = '0, pend_clr = '0;
  logic        stat_we = 1'b0;
  logic [31:0] epc, cause, badaddr, status, redirect_pc;
  logic        redirect_valid;
  int total = 0, bad = 0;
  logic [31:0] exp_epc = '0, exp_bad = '0;
  localparam logic [31:0] VEC = 32'h8000_0080;

  always #2.5 clk = ~clk;

  trap_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pc_next(pc_next),
    .req_ibus(reqs[0]), .req_adrl(reqs[1]), .req_adrs(reqs[2]), .req_dbus(reqs[3]),
    .req_rsvd(reqs[4]), .req_ovf(reqs[5]), .req_sys(reqs[6]), .req_brk(reqs[7]),
    .fault_addr(fault_addr), .irq(irq), .pend_clr(pend_clr),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .epc(epc), .cause(cause), .badaddr(badaddr), .status(status),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // priority of the bench's bit order: bit 0 most urgent
  function automatic logic [3:0] exp_code(input logic [7:0] v);
    logic [3:0] t [8] = '{4'd6, 4'd4, 4'd5, 4'd7, 4'd10, 4'd12, 4'd8, 4'd9};
    for (int i = 0; i < 8; i++) if (v[i]) return t[i];
    return 4'd0;
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic wr_status(input logic [31:0] d);
    stat_we = 1'b1; stat_wdata = d; step(); stat_we = 1'b0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset values
    chk("R9 epc", epc, 0); chk("R9 cause", cause, 0); chk("R9 status", status, 0);
    chk("R9 badaddr", badaddr, 0); chk("R1 idle", {31'b0, redirect_valid}, 0);

    // R1 R2 R3 R4 R5: sweep every fault combination, interrupts disabled
    for (int v = 0; v < 256; v++) begin
      reqs = v[7:0];
      pc_next = 32'h0000_1004 + 32'(v) * 8;
      fault_addr = 32'hA000_0000 | 32'(v);
      step();
      reqs = '0;
      chk("R1 valid", {31'b0, redirect_valid}, {31'b0, v != 0});
      if (v != 0) begin
        exp_epc = 32'h0000_1000 + 32'(v) * 8;
        if (exp_code(v[7:0]) inside {4'd4, 4'd5, 4'd6, 4'd7}) exp_bad = 32'hA000_0000 | 32'(v);
        chk("R1 vector", redirect_pc, VEC);
        chk("R3 R4 code", {28'b0, cause[5:2]}, {28'b0, exp_code(v[7:0])});
      end
      chk("R2 epc", epc, exp_epc);
      chk("R5 badaddr", badaddr, exp_bad);
    end
    step();
    chk("R1 pulse ends", {31'b0, redirect_valid}, 0);

    // R6 R7: each level under every enable / mask pairing
    for (int k = 0; k < 5; k++) begin
      for (int en = 0; en < 2; en++) begin
        for (int um = 0; um < 2; um++) begin
          pend_clr = 5'h1F;
          wr_status(32'(en) | (um != 0 ? (32'h100 << k) : 32'h0));
          pend_clr = '0;
          irq = 5'(1 << k); pc_next = 32'h0000_2000 + 32'(k) * 4;
          step();
          irq = '0;
          chk("R6 pending", {27'b0, cause[12:8]}, 32'(1 << k));
          chk("R7 not yet", {31'b0, redirect_valid}, 0);
          step();
          chk("R7 take", {31'b0, redirect_valid}, {31'b0, (en != 0) && (um != 0)});
          if (en != 0 && um != 0) begin
            chk("R7 code", {28'b0, cause[5:2]}, 0);
            chk("R2 irq epc", epc, 32'h0000_1FFC + 32'(k) * 4);
            chk("R8 ie cleared", {31'b0, status[0]}, 0);
          end else begin
            chk("R8 ie held", {31'b0, status[0]}, 32'(en));
          end
        end
      end
    end

    // R6 R7: latched while masked, taken after unmask
    pend_clr = 5'h1F; wr_status(32'h1); pend_clr = '0;
    irq = 5'b01000; step(); irq = 5'b00010; step(); irq = '0;
    chk("R6 two pending", {27'b0, cause[12:8]}, 32'b01010);
    chk("R7 masked", {31'b0, redirect_valid}, 0);
    pc_next = 32'h0000_3010;
    wr_status(32'h0801);
    chk("R7 before take", {31'b0, redirect_valid}, 0);
    step();
    chk("R7 unmask take", {31'b0, redirect_valid}, 1);
    chk("R2 late epc", epc, 32'h0000_300C);
    pend_clr = 5'b01000; step(); pend_clr = '0;
    chk("R6 ack one", {27'b0, cause[12:8]}, 32'b00010);
    irq = 5'b00010; pend_clr = 5'b00010; step(); irq = '0; pend_clr = '0;
    chk("R6 set wins", {27'b0, cause[12:8]}, 32'b00010);

    // R4: fault beats interrupt, then no interrupt since enable dropped
    wr_status(32'h1F01);
    reqs = 8'h40; pc_next = 32'h0000_4004; step(); reqs = '0;
    chk("R4 sys over irq", {28'b0, cause[5:2]}, 32'd8);
    step();
    chk("R7 no reentry", {31'b0, redirect_valid}, 0);

    // R8: take overrides enable write; mask still written
    stat_we = 1'b1; stat_wdata = 32'h0301; reqs = 8'h20; step();
    stat_we = 1'b0; reqs = '0;
    chk("R8 override", status, 32'h0300);
    // R9: unused status bits stay zero
    pend_clr = 5'h1F; wr_status(32'hFFFF_FFFF); pend_clr = '0;
    chk("R9 status spare", status, 32'h1F01);
    chk("R9 cause spare", cause & ~32'h1F3C, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule